// File: doc/BRIEF.md
# Link Polling Burst Handshake Controller

This block runs the low-frequency burst exchange that opens link training. While in the handshake phase it asks the analog side to emit a burst at a fixed tick interval. It tallies the bursts that the analog side reports as sent and as received. Once enough of both have been seen, and a short run of further bursts has gone out, it hands over to receiver-equalization training.

If the exchange has not completed within a timeout counted in timebase ticks, the block drops into compliance mode. In that mode it selects test patterns for an external generator. It starts at pattern 0 (the scrambled all-zero data pattern) and moves to the next pattern on every detected ping burst, wrapping after a configurable last pattern.

All pins are plain single-cycle control and status signals, and no stream interface is involved. The timeout defaults to 360 ticks, which is 360 ms with a 1 ms tick, and a test configuration can shorten it.

Top module: `lfps_poll_ctrl`

## Requirements
- R1: After a synchronous reset, `state_o` is 0 (handshake), `cp_idx_o` is 0, and `exit_eq_o` and `send_req_o` are low.
- R2: In the handshake phase, `send_req_o` pulses high for one cycle once every REP_TICKS ticks, and its first pulse follows the REP_TICKS-th tick. In any other phase it stays low.
- R3: The block stays in the handshake phase while fewer than TX_MIN (16) sent bursts or fewer than RX_MIN (2) received bursts have been counted.
- R4: TX_AFTER (4) further sent bursts are required, and they count only once the TX_MIN-sent and RX_MIN-received conditions both hold. Sent bursts beyond TX_MIN that arrive before the receive condition do not count toward them.
- R5: The cycle after the last required sent-burst pulse is sampled, `state_o` becomes 1 (equalization exit) and `exit_eq_o` goes high. Both hold until reset.
- R6: After TIMEOUT_TICKS ticks in the handshake phase without completion, `state_o` becomes 2 (compliance) with `cp_idx_o` equal to 0. After TIMEOUT_TICKS-1 ticks the phase is still 0.
- R7: In compliance mode, each ping pulse increments `cp_idx_o` by one.
- R8: A ping while `cp_idx_o` equals CP_LAST returns `cp_idx_o` to 0.
- R9: Pings outside compliance mode leave `cp_idx_o` unchanged. Once the phase is 1 or 2, burst, tick and ping inputs do not change the phase.
- R10: If the handshake completes in the same cycle that the timeout expires, the phase becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timebase tick pulse |
| tx_burst_i | input | 1 | One pulse per burst sent |
| rx_burst_i | input | 1 | One pulse per burst received |
| ping_i | input | 1 | Ping-burst detect pulse |
| state_o | output | 2 | Phase: 0 handshake, 1 equalization exit, 2 compliance |
| send_req_o | output | 1 | Burst-send request pulse |
| cp_idx_o | output | $clog2(CP_LAST+1) | Compliance pattern index |
| exit_eq_o | output | 1 | High once the block has exited to equalization |

## Verification
The handshake is tried in several arrival orders:
- Sent bursts before received ones, swept over 0 to 6 surplus sent bursts. This shows that the four trailing bursts count only after both thresholds are met.
- Received bursts first. This shows the exit comes at exactly 20 sent bursts.
- Received bursts alone, with no sent bursts. This shows the sent threshold is required.

The timeout path is driven tick by tick to separate TIMEOUT_TICKS-1 ticks from TIMEOUT_TICKS ticks. The same run counts request pulses against the tick count.

In compliance mode, pings are swept over more than two full wraps of the pattern index. A final case lands completion and timeout in the same cycle to show that completion wins.

// File: rtl/lfps_poll_pkg.sv
package lfps_poll_pkg;
  typedef enum logic [1:0] {
    PH_HANDSHAKE = 2'd0,
    PH_EQ_EXIT   = 2'd1,
    PH_COMPLY    = 2'd2
  } poll_phase_t;
endpackage

// File: rtl/lfps_burst_tally.sv
module lfps_burst_tally #(
  parameter int TX_MIN   = 16,
  parameter int RX_MIN   = 2,
  parameter int TX_AFTER = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tx_i,
  input  logic rx_i,
  output logic done_o
);
  localparam int TW = $clog2(TX_MIN + 1);
  localparam int RW = $clog2(RX_MIN + 1);
  localparam int AW = $clog2(TX_AFTER + 1);
  localparam logic [TW-1:0] TX_FULL = TW'(TX_MIN);
  localparam logic [RW-1:0] RX_FULL = RW'(RX_MIN);
  localparam logic [AW-1:0] AF_FULL = AW'(TX_AFTER);

  logic [TW-1:0] tx_q;
  logic [RW-1:0] rx_q;
  logic [AW-1:0] af_q;
  logic          armed;

  assign armed  = (tx_q == TX_FULL) && (rx_q == RX_FULL);
  assign done_o = (af_q == AF_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
      af_q <= '0;
    end else if (en_i) begin
      if (tx_i && tx_q != TX_FULL) tx_q <= tx_q + 1'b1;
      if (rx_i && rx_q != RX_FULL) rx_q <= rx_q + 1'b1;
      if (tx_i && armed && af_q != AF_FULL) af_q <= af_q + 1'b1;
    end
  end

  // R4
  after_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (af_q != '0) |-> armed);
  // R4
  after_bound_chk: assert property (@(posedge clk) disable iff (rst)
    af_q <= AF_FULL);
  // R3
  tx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tx_q <= TX_FULL && rx_q <= RX_FULL);
endmodule

// File: rtl/lfps_tick_timer.sv
module lfps_tick_timer #(
  parameter int LIMIT = 360
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (en_i && tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);
endmodule

// File: rtl/lfps_burst_pacer.sv
module lfps_burst_pacer #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  output logic req_o
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] rep_q;
  logic         req_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      rep_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= tick_i && (rep_q == LAST);
      if (tick_i) rep_q <= (rep_q == LAST) ? '0 : rep_q + 1'b1;
    end
  end

  assign req_o = req_q && en_i;

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o || PERIOD == 1);
endmodule

// File: rtl/cmpl_pattern_seq.sv
module cmpl_pattern_seq #(
  parameter int CP_LAST = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en_i,
  input  logic                              ping_i,
  output logic [$clog2(CP_LAST+1)-1:0]      idx_o
);
  localparam int W = $clog2(CP_LAST + 1);
  localparam logic [W-1:0] TOP = W'(CP_LAST);

  logic [W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (en_i && ping_i) idx_q <= (idx_q == TOP) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(en_i && ping_i) |=> $stable(idx_q));
  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= TOP);
endmodule

// File: rtl/lfps_poll_ctrl.sv
module lfps_poll_ctrl
  import lfps_poll_pkg::*;
#(
  parameter int TX_MIN        = 16,
  parameter int RX_MIN        = 2,
  parameter int TX_AFTER      = 4,
  parameter int TIMEOUT_TICKS = 360,
  parameter int REP_TICKS     = 8,
  parameter int CP_LAST       = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick_i,
  input  logic                         tx_burst_i,
  input  logic                         rx_burst_i,
  input  logic                         ping_i,
  output logic [1:0]                   state_o,
  output logic                         send_req_o,
  output logic [$clog2(CP_LAST+1)-1:0] cp_idx_o,
  output logic                         exit_eq_o
);
  poll_phase_t ph_q, ph_d;
  logic in_hs, in_cp, done, expired;

  assign in_hs = (ph_q == PH_HANDSHAKE);
  assign in_cp = (ph_q == PH_COMPLY);

  lfps_burst_tally #(.TX_MIN(TX_MIN), .RX_MIN(RX_MIN), .TX_AFTER(TX_AFTER)) u_tally (
    .clk(clk), .rst(rst), .en_i(in_hs), .tx_i(tx_burst_i), .rx_i(rx_burst_i),
    .done_o(done));

  lfps_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst(rst), .en_i(in_hs), .tick_i(tick_i), .expired_o(expired));

  lfps_burst_pacer #(.PERIOD(REP_TICKS)) u_pacer (
    .clk(clk), .rst(rst), .en_i(in_hs), .tick_i(tick_i), .req_o(send_req_o));

  cmpl_pattern_seq #(.CP_LAST(CP_LAST)) u_seq (
    .clk(clk), .rst(rst), .en_i(in_cp), .ping_i(ping_i), .idx_o(cp_idx_o));

  always_comb begin
    ph_d = ph_q;
    if (in_hs) begin
      if (done)         ph_d = PH_EQ_EXIT;
      else if (expired) ph_d = PH_COMPLY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_HANDSHAKE;
    else     ph_q <= ph_d;
  end

  assign state_o   = ph_q;
  assign exit_eq_o = (ph_q == PH_EQ_EXIT);

  // R5
  phase_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !in_hs |=> $stable(ph_q));
  // R5
  exit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(exit_eq_o) |-> $past(done));
  // R6
  comply_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_cp && $past(ph_q) == PH_HANDSHAKE) |-> ($past(expired) && cp_idx_o == '0));
  // R2
  req_only_hs_chk: assert property (@(posedge clk) disable iff (rst)
    send_req_o |-> in_hs);
endmodule

// File: tb/lfps_poll_ctrl_test.sv
module lfps_poll_ctrl_test;
  localparam int TXM = 16, RXM = 2, TXA = 4, TMO = 40, REP = 3, CPL = 3;
  localparam int IW = $clog2(CPL + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b0, tx = 1'b0, rx = 1'b0, ping = 1'b0;
  logic [1:0] state;
  logic send_req, exit_eq;
  logic [IW-1:0] cp_idx;
  int checks = 0, errors = 0, req_seen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lfps_poll_ctrl #(.TX_MIN(TXM), .RX_MIN(RXM), .TX_AFTER(TXA), .TIMEOUT_TICKS(TMO),
                   .REP_TICKS(REP), .CP_LAST(CPL)) uut (
    .clk(clk), .rst(rst), .tick_i(tick), .tx_burst_i(tx), .rx_burst_i(rx),
    .ping_i(ping), .state_o(state), .send_req_o(send_req), .cp_idx_o(cp_idx),
    .exit_eq_o(exit_eq));

  always @(negedge clk) if (!rst && send_req) req_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit t, input bit r, input bit k, input bit p);
    @(negedge clk);
    tx = t; rx = r; tick = k; ping = p;
    @(negedge clk);
    tx = 0; rx = 0; tick = 0; ping = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    req_seen = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 state", state, 0);
    chk("R1 idx", cp_idx, 0);
    chk("R1 exit", exit_eq, 0);
    chk("R1 req", send_req, 0);

    // R4 sweep: surplus sent bursts before the receive condition
    for (int n = 0; n <= 6; n++) begin
      do_reset();
      for (int i = 0; i < TXM + n; i++) pulse(1, 0, 0, 0);
      settle();
      chk("R3 tx only", state, 0);
      for (int i = 0; i < RXM; i++) pulse(0, 1, 0, 0);
      for (int i = 0; i < TXA - 1; i++) pulse(1, 0, 0, 0);
      settle();
      chk("R4 one short", state, 0);
      pulse(1, 0, 0, 0);
      @(negedge clk);
      chk("R5 state", state, 1);
      chk("R5 exit", exit_eq, 1);
      // R9: inputs ignored after exit
      pulse(0, 0, 1, 1); pulse(1, 1, 0, 1);
      settle();
      chk("R9 eq state", state, 1);
      chk("R9 eq idx", cp_idx, 0);
      chk("R2 eq req", req_seen, 0);
    end

    // R3/R4 receive first: exit at exactly TXM+TXA sent
    do_reset();
    for (int i = 0; i < RXM + 3; i++) pulse(0, 1, 0, 0);
    settle();
    chk("R3 rx only", state, 0);
    for (int i = 0; i < TXM + TXA - 1; i++) pulse(1, 0, 0, 0);
    settle();
    chk("R4 rx first short", state, 0);
    pulse(1, 0, 0, 0);
    @(negedge clk);
    chk("R4 rx first exit", state, 1);

    // R6 timeout and R2 pacing
    do_reset();
    for (int i = 0; i < TMO - 1; i++) pulse(0, 0, 1, 0);
    settle();
    chk("R6 before timeout", state, 0);
    chk("R2 req count", req_seen, (TMO - 1) / REP);
    pulse(0, 0, 1, 0);
    @(negedge clk);
    chk("R6 comply", state, 2);
    chk("R6 idx", cp_idx, 0);
    req_seen = 0;
    // R7/R8 ping sweep over several wraps
    for (int k = 1; k <= 2 * (CPL + 1) + 1; k++) begin
      pulse(0, 0, 0, 1);
      chk("R7 R8 idx", cp_idx, k % (CPL + 1));
    end
    pulse(1, 1, 1, 0);
    for (int i = 0; i < 2 * REP; i++) pulse(0, 0, 1, 0);
    settle();
    chk("R9 comply state", state, 2);
    chk("R2 comply req", req_seen, 0);

    // R9 pings in handshake ignored
    do_reset();
    for (int i = 0; i < 3; i++) pulse(0, 0, 0, 1);
    chk("R9 hs idx", cp_idx, 0);
    chk("R9 hs state", state, 0);

    // R10 completion and timeout in the same cycle
    do_reset();
    for (int i = 0; i < TXM; i++) pulse(1, 0, 0, 0);
    for (int i = 0; i < RXM; i++) pulse(0, 1, 0, 0);
    for (int i = 0; i < TXA - 1; i++) pulse(1, 0, 0, 0);
    for (int i = 0; i < TMO - 1; i++) pulse(0, 0, 1, 0);
    settle();
    chk("R10 pre", state, 0);
    pulse(1, 0, 1, 0);
    @(negedge clk);
    chk("R10 tie", state, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule